// File: doc/BRIEF.md
# Line-Interleaved Banked Data Cache Crossbar

This block connects a small set of processor-side load/store ports to a larger set of single-ported data cache banks. Every request carries a byte address. The cache-line number taken from that address picks the bank. Neighbouring lines therefore land in neighbouring banks, and a stream of accesses that walks through memory spreads across all banks.

A bank takes one request per cycle. When several ports aim at the same bank in one cycle, the lowest-numbered port goes through. Every other port sees a registered retry flag on the next cycle and presents its request again. Each bank is a direct-mapped stub with one data word per line, and it handles its own misses. While a bank refills a line it refuses new work, and the remaining banks carry on as normal. Each response is tagged with the index of the port that issued it, so the data goes back to that port.

Top module: `mbank_xbar`

## Requirements
- R1: A request goes to bank `(addr >> 5) mod NBANKS`, where the line number is the byte address divided by the 32-byte line size. NBANKS is a power of two from 2 to 32.
- R2: A bank accepts no more than one request in any cycle.
- R3: When more than one valid request targets a ready bank in the same cycle, the port with the lowest index is accepted.
- R4: Any valid request that is not accepted at a clock edge raises `req_retry` for that port on the cycle after that edge. An accepted request, or no request, leaves `req_retry` low.
- R5: A hit produces `rsp_vld` on the issuing port in the cycle after acceptance. A load returns the word held for that line. A store writes `req_wdata` into the line and echoes it back as response data.
- R6: A miss makes its bank not ready, and the response appears 5 cycles after acceptance. For a load the line is filled with `(addr >> 5) ^ 32'hA5A5A5A5`. For a store the line is filled with the store data, and that same value is returned.
- R7: A bank that is refilling turns away every request aimed at it, and those requests get retry. Banks that are not refilling keep accepting requests and answering hits in the same cycles.
- R8: Within a bank, the set index is address bits [9:8] and the tag is bits [31:10]. A different tag in the same set replaces the line, and dirty data is dropped without write-back. A later access to the replaced line misses.
- R9: While reset is held and after it is released, the outputs `req_retry` and `rsp_vld` stay low, and every line is invalid.
- R10: Each response returns only on the port that issued the request, and no port receives two responses in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | NPORTS | Request present on each port |
| req_wr | input | NPORTS | 1 = store, 0 = load |
| req_addr | input | NPORTS x ADDR_W | Byte address for each port |
| req_wdata | input | NPORTS x DATA_W | Store data for each port |
| req_retry | output | NPORTS | Registered flag: the previous cycle's request was not taken |
| rsp_vld | output | NPORTS | Response valid on each port |
| rsp_data | output | NPORTS x DATA_W | Load data, or the echoed store data |

## Verification
The per-port response check (R10) relies on each port keeping at most one request outstanding. A port must not issue a new request until the response to its previous request has arrived. A retried port must present the same request again. The stimulus tracks a small state per port: idle, presenting, or waiting for a response. A port is only given a new request when it is idle, and a retried request is held unchanged. Addresses are drawn from a few tags, sets and banks so that conflicts, refills and evictions occur often.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   typedef enum logic {BK_READY, BK_REFILL} bank_st_e;
   localparam logic [31:0] FILL_KEY_DFLT = 32'hA5A5_A5A5;
endpackage

// File: rtl/mbx_arb.sv
module mbx_arb #(
   parameter int NREQ = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NREQ-1:0] req,
   output logic [NREQ-1:0] gnt
);
   always_comb begin
      logic found;
      found = 1'b0;
      gnt   = '0;
      for (int i = 0; i < NREQ; i++) begin
         if (req[i] && !found) begin
            gnt[i] = 1'b1;
            found  = 1'b1;
         end
      end
   end

   // R2
   gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));
   // R3
   gnt_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt != '0) |-> ((req & (gnt - 1'b1)) == '0) && ((gnt & ~req) == '0));
endmodule

// File: rtl/mbx_bank.sv
module mbx_bank
   import mbx_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int OFF_W    = 5,
   parameter int BANK_W   = 3,
   parameter int SETS     = 4,
   parameter int MISS_LAT = 5,
   parameter int PIDX_W   = 2,
   parameter logic [DATA_W-1:0] FILL_KEY = '0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    take,
   input  logic [PIDX_W-1:0]       take_port,
   input  logic                    take_wr,
   input  logic [ADDR_W-OFF_W-1:0] take_line,
   input  logic [DATA_W-1:0]       take_wdata,
   output logic                    ready,
   output logic                    rsp_vld,
   output logic [PIDX_W-1:0]       rsp_port,
   output logic [DATA_W-1:0]       rsp_data
);
   localparam int LINE_W = ADDR_W - OFF_W;
   localparam int SET_W  = $clog2(SETS);
   localparam int TAG_W  = LINE_W - BANK_W - SET_W;
   localparam int CNT_W  = $clog2(MISS_LAT);

   bank_st_e          state;
   logic [CNT_W-1:0]  cnt;
   logic [SETS-1:0]   vld;
   logic [TAG_W-1:0]  tagm [SETS];
   logic [DATA_W-1:0] dat  [SETS];

   logic [PIDX_W-1:0] m_port;
   logic              m_wr;
   logic [DATA_W-1:0] m_word;
   logic [SET_W-1:0]  m_set;
   logic [TAG_W-1:0]  m_tag;

   logic [SET_W-1:0]  set_i;
   logic [TAG_W-1:0]  tag_i;
   logic [DATA_W-1:0] fill_i;
   logic              hit;

   assign set_i  = take_line[BANK_W +: SET_W];
   assign tag_i  = take_line[LINE_W-1 -: TAG_W];
   assign fill_i = DATA_W'(take_line) ^ FILL_KEY;
   assign hit    = vld[set_i] && (tagm[set_i] == tag_i);
   assign ready  = (state == BK_READY);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= BK_READY;
         cnt      <= '0;
         vld      <= '0;
         rsp_vld  <= 1'b0;
         rsp_port <= '0;
         rsp_data <= '0;
         m_port   <= '0;
         m_wr     <= 1'b0;
         m_word   <= '0;
         m_set    <= '0;
         m_tag    <= '0;
      end else begin
         rsp_vld <= 1'b0;
         if (state == BK_REFILL) begin
            if (cnt == '0) begin
               vld[m_set]  <= 1'b1;
               tagm[m_set] <= m_tag;
               dat[m_set]  <= m_word;
               rsp_vld     <= 1'b1;
               rsp_port    <= m_port;
               rsp_data    <= m_word;
               state       <= BK_READY;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end else if (take) begin
            if (hit) begin
               rsp_vld  <= 1'b1;
               rsp_port <= take_port;
               if (take_wr) begin
                  dat[set_i] <= take_wdata;
                  rsp_data   <= take_wdata;
               end else begin
                  rsp_data <= dat[set_i];
               end
            end else begin
               state  <= BK_REFILL;
               cnt    <= CNT_W'(MISS_LAT - 1);
               m_port <= take_port;
               m_wr   <= take_wr;
               m_word <= take_wr ? take_wdata : fill_i;
               m_set  <= set_i;
               m_tag  <= tag_i;
            end
         end
      end
   end

   // R7
   take_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) !ready |-> !take);
   // R5
   hit_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && hit) |=> (rsp_vld && ready && rsp_port == $past(take_port)));
   // R6
   miss_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !hit) |=> (!ready && !rsp_vld));
   // R6
   fill_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && cnt == '0) |=> (rsp_vld && ready));
endmodule

// File: rtl/mbank_xbar.sv
module mbank_xbar
   import mbx_pkg::*;
#(
   parameter int NPORTS     = 4,
   parameter int NBANKS     = 8,
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int LINE_BYTES = 32,
   parameter int SETS       = 4,
   parameter int MISS_LAT   = 5,
   parameter logic [DATA_W-1:0] FILL_KEY = FILL_KEY_DFLT
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NPORTS-1:0]              req_vld,
   input  logic [NPORTS-1:0]              req_wr,
   input  logic [NPORTS-1:0][ADDR_W-1:0]  req_addr,
   input  logic [NPORTS-1:0][DATA_W-1:0]  req_wdata,
   output logic [NPORTS-1:0]              req_retry,
   output logic [NPORTS-1:0]              rsp_vld,
   output logic [NPORTS-1:0][DATA_W-1:0]  rsp_data
);
   localparam int OFF_W  = $clog2(LINE_BYTES);
   localparam int BANK_W = $clog2(NBANKS);
   localparam int PIDX_W = $clog2(NPORTS);
   localparam int LINE_W = ADDR_W - OFF_W;

   if (NBANKS < 2 || NBANKS > 32 || (1 << BANK_W) != NBANKS) begin : bad_nbanks
      $error("NBANKS must be a power of two from 2 to 32");
   end
   if (NPORTS < 2 || (1 << PIDX_W) != NPORTS) begin : bad_nports
      $error("NPORTS must be a power of two of at least 2");
   end
   if (MISS_LAT < 2 || SETS < 2 || (1 << $clog2(SETS)) != SETS) begin : bad_bank_cfg
      $error("MISS_LAT must be at least 2 and SETS a power of two of at least 2");
   end

   logic [NPORTS-1:0] gnt_all [NBANKS];
   logic [NPORTS-1:0] breq_all [NBANKS];
   logic              bk_rdy  [NBANKS];
   logic              bk_rv   [NBANKS];
   logic [PIDX_W-1:0] bk_rp   [NBANKS];
   logic [DATA_W-1:0] bk_rd   [NBANKS];
   logic [NPORTS-1:0] accepted;
   logic [NBANKS-1:0] phit [NPORTS];
   logic              unused_off;

   always_comb begin
      unused_off = 1'b0;
      for (int p = 0; p < NPORTS; p++) unused_off = unused_off ^ (^req_addr[p][OFF_W-1:0]);
   end

   for (genvar b = 0; b < NBANKS; b++) begin : g_bank
      logic [PIDX_W-1:0] bpidx;
      logic              btake;

      always_comb begin
         for (int p = 0; p < NPORTS; p++)
            breq_all[b][p] = req_vld[p] && (req_addr[p][OFF_W +: BANK_W] == BANK_W'(b));
      end

      mbx_arb #(.NREQ(NPORTS)) u_arb (
         .clk (clk), .rst_n (rst_n), .req (breq_all[b]), .gnt (gnt_all[b])
      );

      always_comb begin
         bpidx = '0;
         for (int p = 0; p < NPORTS; p++)
            if (gnt_all[b][p]) bpidx = PIDX_W'(p);
      end
      assign btake = (|gnt_all[b]) && bk_rdy[b];

      mbx_bank #(
         .ADDR_W (ADDR_W), .DATA_W (DATA_W), .OFF_W (OFF_W), .BANK_W (BANK_W),
         .SETS (SETS), .MISS_LAT (MISS_LAT), .PIDX_W (PIDX_W), .FILL_KEY (FILL_KEY)
      ) u_bank (
         .clk        (clk),
         .rst_n      (rst_n),
         .take       (btake),
         .take_port  (bpidx),
         .take_wr    (req_wr[bpidx]),
         .take_line  (req_addr[bpidx][ADDR_W-1:OFF_W]),
         .take_wdata (req_wdata[bpidx]),
         .ready      (bk_rdy[b]),
         .rsp_vld    (bk_rv[b]),
         .rsp_port   (bk_rp[b]),
         .rsp_data   (bk_rd[b])
      );

      // R7
      busy_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !bk_rdy[b] |=> ((req_retry & $past(breq_all[b])) == $past(breq_all[b])));
   end

   always_comb begin
      accepted = '0;
      for (int b = 0; b < NBANKS; b++)
         if (bk_rdy[b]) accepted = accepted | gnt_all[b];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) req_retry <= '0;
      else        req_retry <= req_vld & ~accepted;
   end

   always_comb begin
      for (int p = 0; p < NPORTS; p++) begin
         rsp_vld[p]  = 1'b0;
         rsp_data[p] = '0;
         phit[p]     = '0;
         for (int b = 0; b < NBANKS; b++) begin
            if (bk_rv[b] && bk_rp[b] == PIDX_W'(p)) begin
               phit[p][b]  = 1'b1;
               rsp_vld[p]  = 1'b1;
               rsp_data[p] = rsp_data[p] | bk_rd[b];
            end
         end
      end
   end

   for (genvar p = 0; p < NPORTS; p++) begin : g_port_chk
      // R4
      retry_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
         req_retry[p] |-> $past(req_vld[p]));
      // R10
      rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(phit[p]));
   end
endmodule

// File: tb/tb_mbank_xbar.sv
module tb_mbank_xbar;
   localparam int NP = 4, NB = 8, NS = 4, ML = 5;
   localparam logic [31:0] KEY = 32'hA5A5_A5A5;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n;
   logic [NP-1:0] req_vld, req_wr, req_retry, rsp_vld;
   logic [NP-1:0][31:0] req_addr, req_wdata, rsp_data;

   mbank_xbar dut (
      .clk (clk), .rst_n (rst_n), .req_vld (req_vld), .req_wr (req_wr),
      .req_addr (req_addr), .req_wdata (req_wdata), .req_retry (req_retry),
      .rsp_vld (rsp_vld), .rsp_data (rsp_data)
   );

   int checks = 0, fails = 0, cyc = 0;
   bit          mv [NB][NS];
   logic [31:0] mt [NB][NS];
   logic [31:0] md [NB][NS];
   bit          mbusy [NB];
   int          mcnt [NB], mport [NB], mset [NB];
   logic [31:0] mtag [NB], mword [NB];
   bit          exp_retry [NP], exp_rv [NP], acc [NP];
   logic [31:0] exp_rd [NP];
   int          pstate [NP];
   int          last_rsp [NP];
   logic [31:0] last_data [NP];

   task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s at cycle %0d: actual %h expected %h", rq, what, cyc, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(int tag, int set, int bank, int off);
      return (32'(tag) << 10) | (32'(set) << 8) | (32'(bank) << 5) | 32'(off);
   endfunction

   task automatic set_req(int p, bit wr, logic [31:0] a, logic [31:0] wd);
      req_vld[p] = 1'b1; req_wr[p] = wr; req_addr[p] = a; req_wdata[p] = wd;
      pstate[p] = 1;
   endtask

   task automatic model_step();
      bit rdy [NB];
      bit taken [NB];
      for (int p = 0; p < NP; p++) begin exp_rv[p] = 0; exp_retry[p] = 0; acc[p] = 0; end
      for (int b = 0; b < NB; b++) begin
         rdy[b] = !mbusy[b]; taken[b] = 0;
         if (mbusy[b]) begin
            if (mcnt[b] == 0) begin
               mv[b][mset[b]] = 1; mt[b][mset[b]] = mtag[b]; md[b][mset[b]] = mword[b];
               exp_rv[mport[b]] = 1; exp_rd[mport[b]] = mword[b]; mbusy[b] = 0;
            end else mcnt[b]--;
         end
      end
      for (int p = 0; p < NP; p++) begin
         if (req_vld[p]) begin
            logic [31:0] a;
            int b, s;
            a = req_addr[p]; b = int'((a >> 5) % NB); s = int'((a >> 8) % NS);
            if (rdy[b] && !taken[b]) begin
               taken[b] = 1; acc[p] = 1;
               if (mv[b][s] && mt[b][s] == (a >> 10)) begin
                  if (req_wr[p]) md[b][s] = req_wdata[p];
                  exp_rv[p] = 1; exp_rd[p] = md[b][s];
               end else begin
                  mbusy[b] = 1; mcnt[b] = ML - 1; mport[b] = p; mset[b] = s;
                  mtag[b] = a >> 10;
                  mword[b] = req_wr[p] ? req_wdata[p] : ((a >> 5) ^ KEY);
               end
            end else exp_retry[p] = 1;
         end
      end
   endtask

   task automatic cycle();
      model_step();
      @(posedge clk);
      cyc++;
      @(negedge clk);
      for (int p = 0; p < NP; p++) begin
         chk("R2 R3 R4 R7", $sformatf("retry[%0d]", p), 32'(req_retry[p]), 32'(exp_retry[p]));
         chk("R5 R6 R10", $sformatf("rsp_vld[%0d]", p), 32'(rsp_vld[p]), 32'(exp_rv[p]));
         if (exp_rv[p]) chk("R5 R6 R8", $sformatf("rsp_data[%0d]", p), rsp_data[p], exp_rd[p]);
         if (rsp_vld[p]) begin last_rsp[p] = cyc; last_data[p] = rsp_data[p]; end
         if (acc[p]) begin req_vld[p] = 1'b0; pstate[p] = 2; end
         if (exp_rv[p]) pstate[p] = 0;
      end
   endtask

   task automatic run_idle();
      for (int k = 0; k < 100; k++) begin
         bit busy;
         busy = 0;
         for (int p = 0; p < NP; p++) if (pstate[p] != 0) busy = 1;
         for (int b = 0; b < NB; b++) if (mbusy[b]) busy = 1;
         if (!busy) break;
         cycle();
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL R9 watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      int t0;
      rst_n = 1'b0; req_vld = '0; req_wr = '0; req_addr = '0; req_wdata = '0;
      for (int p = 0; p < NP; p++) pstate[p] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R9", "retry in reset", 32'(req_retry), 32'h0);
      chk("R9", "rsp_vld in reset", 32'(rsp_vld), 32'h0);
      rst_n = 1'b1;

      // R1 R3 R4: ports 0,1,3 hit bank 0, port 2 hits bank 1
      set_req(0, 0, mk(0, 0, 0, 4), 0);
      set_req(1, 0, mk(1, 0, 0, 0), 0);
      set_req(2, 0, mk(0, 0, 1, 8), 0);
      set_req(3, 1, mk(0, 1, 0, 0), 32'hCAFE_0003);
      cycle();
      t0 = cyc;
      chk("R1 R3", "retry pattern", 32'(req_retry), 32'b1010);
      run_idle();
      chk("R6", "miss latency port0", 32'(last_rsp[0]), 32'(t0 + ML));
      chk("R10", "bank1 response on port2", 32'(last_rsp[2]), 32'(t0 + ML));

      // R7: bank 2 refilling, bank 1 keeps serving hits
      set_req(0, 0, mk(0, 0, 2, 0), 0);
      cycle();
      set_req(1, 0, mk(0, 0, 2, 12), 0);
      set_req(2, 0, mk(0, 0, 1, 0), 0);
      cycle();
      chk("R7", "busy bank retry", 32'(req_retry[1]), 32'h1);
      chk("R7", "other bank hit", 32'(rsp_vld[2]), 32'h1);
      run_idle();

      // R8: store hit, evict by another tag, refetch misses with fill data
      set_req(0, 1, mk(0, 0, 1, 0), 32'h1234_5678);
      run_idle();
      chk("R5", "store echo", last_data[0], 32'h1234_5678);
      set_req(0, 0, mk(2, 0, 1, 0), 0);
      run_idle();
      set_req(0, 0, mk(0, 0, 1, 0), 0);
      cycle();
      t0 = cyc;
      run_idle();
      chk("R8", "evicted line misses", 32'(last_rsp[0]), 32'(t0 + ML));
      chk("R8", "evicted line refilled", last_data[0], (mk(0, 0, 1, 0) >> 5) ^ KEY);

      for (int i = 0; i < 3000; i++) begin
         for (int p = 0; p < NP; p++) begin
            if (pstate[p] == 0 && ($urandom % 3) == 0)
               set_req(p, ($urandom % 3) == 0,
                       mk(int'($urandom % 3), int'($urandom % 2), int'($urandom % 5), int'($urandom % 32)),
                       $urandom);
         end
         cycle();
      end
      run_idle();
      finish_run();
   end
endmodule